// File: doc/BRIEF.md
# Per-Frame Status Flag Serializer

The block gathers eight one-bit status flags once per audio frame and sends them out one after another on a single flag pin. A one-cycle frame strobe captures the flags. The first flag sent is the subcode sync after the FIFO delay, which ties the serial stream to the audio at the converter output. The other seven flags describe how the error corrector and the interpolator handled that frame. The frame rate is 7.35 kHz times the disc speed.

The flags are spread evenly over the frame. Each one is held for a fixed number of clock cycles, and the pin returns low once the eighth flag has been sent. The block can also copy the flag stream into the least significant bit of the 24-bit sample word that goes to the digital audio interface encoder. That bit is bit 4 of the interface frame. A configuration bit turns this on. When the bit is clear, the sample word passes through unchanged.

Top module: `flag_serializer`

## Requirements
- R1: On a cycle where `frame_stb` is high, the block captures one flag vector. F2 comes from `status_i[6]` and F8 comes from `status_i[0]`, with the bits in between in descending order.
- R2: Every flag is held on `flag_pin` for exactly `BIT_CYC` cycles. The first flag appears in the cycle right after the strobe edge.
- R3: F1 is the value of `sync_dly` sampled at the strobe edge, and it is the first flag sent.
- R4: The flags leave in the order F1, F2, ..., F8. After F8, `flag_pin` goes low and stays low until the next strobe.
- R5: While `ins_en` is 1, `aud_o[0]` equals the current `flag_pin` value, and `aud_o[23:1]` equals `aud_i[23:1]`.
- R6: While `ins_en` is 0, `aud_o` equals `aud_i` on every bit.
- R7: A strobe that arrives while a frame is still being sent drops the rest of that frame. Sending then restarts at F1 with the newly captured vector.
- R8: While reset is active, and after it until the first strobe, `flag_pin` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb | input | 1 | One-cycle pulse at each frame start |
| sync_dly | input | 1 | Subcode sync after the FIFO delay (becomes F1) |
| status_i | input | 7 | Corrector and interpolator flags F2..F8 (bit 6 = F2) |
| ins_en | input | 1 | Turns on insertion of the flags into the sample LSB |
| aud_i | input | 24 | Sample word from the audio path |
| aud_o | output | 24 | Sample word sent to the interface encoder |
| flag_pin | output | 1 | Serial flag output |

## Verification
The bench varies the sync value and uses vectors of all ones, alternating bits and single set bits. These catch a design that reverses the flag order or drops F1. Because every cycle is checked, a slot one cycle too long or too short shows up as a mismatch at a slot boundary. The bench also sends a strobe halfway through a frame. A design that finishes the old frame, or keeps its half-done bit count, sends the wrong flags at that point. It toggles `ins_en` while a frame is being sent, which exposes any leak of flag bits into the passthrough word, or of stale audio into the inserted LSB.

// File: rtl/flag_serializer.sv
module flag_serializer #(
  parameter int NUM_FLAGS = 8,
  parameter int BIT_CYC   = 16,
  parameter int AUD_W     = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_stb,
  input  logic                 sync_dly,
  input  logic [NUM_FLAGS-2:0] status_i,
  input  logic                 ins_en,
  input  logic [AUD_W-1:0]     aud_i,
  output logic [AUD_W-1:0]     aud_o,
  output logic                 flag_pin
);
  localparam int IDX_W = $clog2(NUM_FLAGS);
  localparam int CNT_W = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BIT_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_FLAGS - 1);

  logic [NUM_FLAGS-1:0] sreg_q;
  logic [IDX_W-1:0]     idx_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (frame_stb) begin
      sreg_q <= {sync_dly, status_i};
      idx_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q  <= '0;
        sreg_q <= sreg_q << 1;
        if (idx_q == IDX_LAST) busy_q <= 1'b0;
        else                   idx_q  <= idx_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign flag_pin = busy_q & sreg_q[NUM_FLAGS-1];
  assign aud_o    = ins_en ? {aud_i[AUD_W-1:1], flag_pin} : aud_i;
endmodule

module flag_serializer_chk #(
  parameter int BIT_CYC = 16,
  parameter int AUD_W   = 24,
  parameter int CNT_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_stb,
  input logic             sync_dly,
  input logic             ins_en,
  input logic [AUD_W-1:0] aud_i,
  input logic [AUD_W-1:0] aud_o,
  input logic             flag_pin,
  input logic             busy,
  input logic [CNT_W-1:0] cnt
);
  assert_first_is_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> flag_pin == $past(sync_dly));

  assert_hold_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_stb && cnt != CNT_W'(BIT_CYC - 1)) |=> $stable(flag_pin));

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> (busy && cnt == '0));

  assert_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !flag_pin);

  assert_insert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> (aud_o[0] == flag_pin && aud_o[AUD_W-1:1] == aud_i[AUD_W-1:1]));

  assert_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_en |-> aud_o == aud_i);
endmodule

bind flag_serializer flag_serializer_chk #(
  .BIT_CYC(BIT_CYC), .AUD_W(AUD_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .sync_dly(sync_dly),
  .ins_en(ins_en), .aud_i(aud_i), .aud_o(aud_o), .flag_pin(flag_pin),
  .busy(busy_q), .cnt(cnt_q)
);

// File: tb/flag_serializer_tb.sv
module flag_serializer_tb_top;
  localparam int S = 16;

  typedef struct {
    logic  val;
    string req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_stb = 1'b0;
  logic        sync_dly = 1'b0;
  logic [6:0]  status_i = '0;
  logic        ins_en = 1'b0;
  logic [23:0] aud_i = '0;
  logic [23:0] aud_o;
  logic        flag_pin;

  int   total = 0;
  int   bad = 0;
  bit   done = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  flag_serializer #(.BIT_CYC(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .sync_dly(sync_dly),
    .status_i(status_i), .ins_en(ins_en), .aud_i(aud_i), .aud_o(aud_o),
    .flag_pin(flag_pin)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // driver: strobe at a negedge, drop stale expectations, push the new frame
  task automatic send_frame(input logic sync, input logic [6:0] st);
    @(negedge clk);
    frame_stb = 1'b1;
    sync_dly  = sync;
    status_i  = st;
    q.delete();
    for (int i = 0; i < 8; i++) begin
      exp_t e;
      e.val = (i == 0) ? sync : st[7-i];
      e.req = (i == 0) ? "R3" : "R1";
      for (int c = 0; c < S; c++) q.push_back(e);
    end
    begin
      exp_t z;
      z.val = 1'b0;
      z.req = "R4";
      q.push_back(z);
    end
    @(negedge clk);
    frame_stb = 1'b0;
    sync_dly  = ~sync;
    status_i  = ~st;
  endtask

  // monitor: one expected pin value per cycle after each edge
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #1;
      if (!rst_n) continue;
      if (q.size() > 0) e = q.pop_front();
      else begin e.val = 1'b0; e.req = "R4"; end
      chk({e.req, " flag_pin (R2 slot)"}, {23'd0, flag_pin}, {23'd0, e.val});
      chk(ins_en ? "R5 aud_o" : "R6 aud_o", aud_o,
          ins_en ? {aud_i[23:1], e.val} : aud_i);
    end
  end

  // stimulus on audio and insert-enable, changed away from edges
  initial begin
    forever begin
      @(negedge clk);
      aud_i = 24'($urandom);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset pin", {23'd0, flag_pin}, 24'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 idle after reset", {23'd0, flag_pin}, 24'd0);

    send_frame(1'b1, 7'b1111111);
    repeat (8*S + 4) @(negedge clk);
    send_frame(1'b0, 7'b1010101);
    repeat (8*S + 4) @(negedge clk);
    ins_en = 1'b1;
    send_frame(1'b1, 7'b0000001);
    repeat (3*S + 5) @(negedge clk);
    ins_en = 1'b0;
    repeat (5*S) @(negedge clk);
    ins_en = 1'b1;
    send_frame(1'b0, 7'b1000000);
    repeat (8*S + 4) @(negedge clk);
    // R7: restart in the middle of a frame
    send_frame(1'b1, 7'b0110011);
    repeat (3*S + 3) @(negedge clk);
    send_frame(1'b0, 7'b1100110);
    repeat (8*S + 4) @(negedge clk);
    ins_en = 1'b0;
    send_frame(1'b1, 7'b0000000);
    repeat (8*S + 6) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule